// File: doc/BRIEF.md
# Fifteen-Cent Candy Release Controller

This synchronous controller runs a vending slot that sells one item for fifteen cents and returns no change. On every clock edge it samples a nickel-detect line, a dime-detect line and a synchronous reset. It keeps the credit paid so far, which is one of 0, 5, 10 or 15 cents. It drives a release line once the price is reached. Any credit beyond the price is absorbed. Coins that arrive after the price is reached are also absorbed.

The parameter `MEALY_RELEASE` selects when the release line asserts. When it is 0, the release line depends only on the stored credit and asserts one cycle after the price is reached. When it is 1, the release line also looks at the coin inputs of the current cycle. It then asserts in the same cycle as the coin that completes the price. A cycle with both coin lines high is refused: the credit is unchanged and an error flag is raised for one cycle.

Top module: `candy_release_ctrl`

## Requirements
- R1: When `rst` is high at a clock edge, `credit` becomes 00 and `coin_err` becomes 0 after that edge. In both styles `release_o` is 0 in the following cycle unless a completing coin arrives in that cycle.
- R2: With `rst` low and only `nickel` high, credit steps 0→5→10. With only `dime` high, credit goes 0→10.
- R3: The step to 15 cents happens on a dime at 5 cents, or on either single coin at 10 cents; the credit never exceeds 15.
- R4: With `rst`, `nickel` and `dime` all low, the credit is unchanged at the next edge.
- R5: At 15 cents the credit stays at 15 whatever the coin inputs are, until a clock edge with `rst` high.
- R6: With `rst` low and both coin lines high, the credit is unchanged. `coin_err` is 1 for exactly the next cycle. `coin_err` is 0 after any other input.
- R7: With `MEALY_RELEASE`=0, `release_o` is 1 exactly when `credit` is 11.
- R8: With `MEALY_RELEASE`=1, `release_o` is 1 when `rst` is low and one of these holds: `credit` is 11; `credit` is 01 with only `dime` high; `credit` is 10 with exactly one coin line high. Otherwise it is 0.
- R9: `credit` encodes the credit as 00 for 0 cents, 01 for 5 cents, 10 for 10 cents and 11 for 15 cents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nickel | input | 1 | Five-cent coin detected this cycle |
| dime | input | 1 | Ten-cent coin detected this cycle |
| release_o | output | 1 | Release the item |
| credit | output | 2 | Stored credit code |
| coin_err | output | 1 | Both coin lines were high in the previous cycle |

## Verification
A wrong stored credit appears on `credit` at the first edge after the faulty transition. In the state-based style it also shows on `release_o` in that cycle, once 15 cents is involved. In the transition-based style a wrong credit changes `release_o` in the same cycle as the coin that should complete the price. All sequences of up to four input codes (idle, nickel, dime, both) are applied after a reset to both styles. This exposes every faulty arc of the four-state graph within at most four cycles. A reset applied while the credit is full checks the only exit from the 15-cent state.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int CREDIT_W = 2;

    typedef enum logic [CREDIT_W-1:0] {
        CR_0  = 2'b00,
        CR_5  = 2'b01,
        CR_10 = 2'b10,
        CR_15 = 2'b11
    } credit_t;

    typedef enum logic [1:0] {
        COIN_NONE,
        COIN_NICKEL,
        COIN_DIME,
        COIN_BOTH
    } coin_t;

    typedef struct packed {
        credit_t credit;
        logic    err;
    } ctrl_state_t;
endpackage

// File: rtl/vend_coin_classify.sv
module vend_coin_classify
    import vend_pkg::*;
(
    input  logic  nickel,
    input  logic  dime,
    output coin_t coin
);
    always_comb begin
        unique case ({nickel, dime})
            2'b00:   coin = COIN_NONE;
            2'b10:   coin = COIN_NICKEL;
            2'b01:   coin = COIN_DIME;
            default: coin = COIN_BOTH;
        endcase
    end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
    import vend_pkg::*;
(
    input  logic    rst,
    input  credit_t cur,
    input  coin_t   coin,
    output credit_t nxt,
    output logic    err_d,
    output logic    reach_full
);
    always_comb begin
        nxt        = cur;
        err_d      = 1'b0;
        reach_full = 1'b0;
        if (rst) begin
            nxt = CR_0;
        end else if (coin == COIN_BOTH) begin
            err_d = 1'b1;
        end else if (cur != CR_15) begin
            unique case (coin)
                COIN_NICKEL: nxt = (cur == CR_0) ? CR_5 : (cur == CR_5) ? CR_10 : CR_15;
                COIN_DIME:   nxt = (cur == CR_0) ? CR_10 : CR_15;
                default:     nxt = cur;
            endcase
            reach_full = (nxt == CR_15);
        end
    end
endmodule

// File: rtl/vend_release_out.sv
module vend_release_out
    import vend_pkg::*;
#(
    parameter bit MEALY_RELEASE = 1'b0
) (
    input  logic    rst,
    input  credit_t cur,
    input  logic    reach_full,
    output logic    release_o
);
    generate
        if (MEALY_RELEASE) begin : g_mealy
            always_comb release_o = !rst && ((cur == CR_15) || reach_full);
        end else begin : g_moore
            always_comb release_o = (cur == CR_15);
        end
    endgenerate
endmodule

// File: rtl/candy_release_ctrl.sv
module candy_release_ctrl
    import vend_pkg::*;
#(
    parameter bit MEALY_RELEASE = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                nickel,
    input  logic                dime,
    output logic                release_o,
    output logic [CREDIT_W-1:0] credit,
    output logic                coin_err
);
    ctrl_state_t st_d, st_q;
    coin_t       coin;
    credit_t     cr_nxt;
    logic        err_nxt;
    logic        reach_full;

    vend_coin_classify u_cls (
        .nickel (nickel),
        .dime   (dime),
        .coin   (coin)
    );

    vend_credit_next u_nxt (
        .rst        (rst),
        .cur        (st_q.credit),
        .coin       (coin),
        .nxt        (cr_nxt),
        .err_d      (err_nxt),
        .reach_full (reach_full)
    );

    vend_release_out #(.MEALY_RELEASE(MEALY_RELEASE)) u_rel (
        .rst        (rst),
        .cur        (st_q.credit),
        .reach_full (reach_full),
        .release_o  (release_o)
    );

    always_comb begin
        st_d.credit = cr_nxt;
        st_d.err    = err_nxt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign credit   = st_q.credit;
    assign coin_err = st_q.err;

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (credit == 2'b00 && !coin_err));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!nickel && !dime) |=> $stable(credit));

    p_full_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (credit == 2'b11) |=> (credit == 2'b11));

    p_both_refused_r6: assert property (@(posedge clk) disable iff (rst)
        (nickel && dime) |=> (coin_err && $stable(credit)));

    p_err_single_r6: assert property (@(posedge clk) disable iff (rst)
        !(nickel && dime) |=> !coin_err);

    p_no_skip_r3: assert property (@(posedge clk) disable iff (rst)
        (credit == 2'b00) |=> (credit != 2'b11));

    generate
        if (MEALY_RELEASE) begin : g_chk_mealy
            p_mealy_early_r8: assert property (@(posedge clk) disable iff (rst)
                (credit == 2'b10 && (nickel ^ dime)) |-> release_o);
        end else begin : g_chk_moore
            p_moore_late_r7: assert property (@(posedge clk) disable iff (rst)
                (credit == 2'b10 && (nickel ^ dime)) |-> !release_o ##1 release_o);
        end
    endgenerate
endmodule

// File: tb/sim_candy_release_ctrl.sv
module sim_candy_release_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic rel_moore, rel_mealy, err_moore, err_mealy;
    logic [1:0] cr_moore, cr_mealy;

    int compared = 0;
    int mismatched = 0;
    int cur_c = 0;
    bit err_m = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    candy_release_ctrl #(.MEALY_RELEASE(1'b0)) u0 (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime),
        .release_o(rel_moore), .credit(cr_moore), .coin_err(err_moore));

    candy_release_ctrl #(.MEALY_RELEASE(1'b1)) u1 (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime),
        .release_o(rel_mealy), .credit(cr_mealy), .coin_err(err_mealy));

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // R9: code = cents / 5
    task automatic step(input bit r, input bit n, input bit d);
        bit mealy_exp;
        @(negedge clk);
        check("R2/R3/R9 credit moore", cr_moore, cur_c / 5);
        check("R2/R3/R9 credit mealy", cr_mealy, cur_c / 5);
        check("R7 moore release", rel_moore, cur_c == 15);
        check("R6 err moore", err_moore, err_m);
        check("R6 err mealy", err_mealy, err_m);
        rst = r; nickel = n; dime = d;
        #1;
        mealy_exp = !r && (cur_c == 15 || (cur_c == 5 && d && !n) || (cur_c == 10 && (n ^ d)));
        check("R8 mealy release", rel_mealy, mealy_exp);
        if (r) begin
            cur_c = 0; err_m = 0;
        end else if (n && d) begin
            err_m = 1;
        end else begin
            err_m = 0;
            if (n) cur_c = cur_c + 5;
            else if (d) cur_c = cur_c + 10;
            if (cur_c > 15) cur_c = 15;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual 0 expected 1 (finished)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        step(1, 0, 0);
        step(1, 1, 1);
        // R1 reset state
        step(0, 0, 0);
        // R2..R6, R7, R8: every sequence of up to four input codes
        for (int seq = 0; seq < 256; seq++) begin
            step(1, 0, 0);
            for (int k = 0; k < 4; k++) begin
                int code = (seq >> (2 * k)) & 3;
                step(0, code[0], code[1]);
            end
        end
        // R5: full credit sticks, R1: reset leaves it
        step(1, 0, 0);
        step(0, 0, 1);
        step(0, 1, 0);
        for (int k = 0; k < 4; k++) step(0, k[0], k[1]);
        step(1, 1, 0);
        step(0, 0, 0);
        // R4: idle holds at each level
        step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
        step(0, 1, 0); step(0, 0, 0);
        step(0, 0, 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule